// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel byte into one asynchronous serial frame on a single output line. A producer offers a byte with a valid/ready handshake. An external divider supplies a baud tick that is sixteen times the bit rate. The frame is made of a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. The line stays high between frames.

An 8-bit line control word sets the frame shape. It chooses the word length, the stop length, whether a parity bit is sent and how that bit is formed (odd, even, or a fixed constant). The word also has a break control that pulls the line low. The block copies the format fields into a register when it accepts a byte, so a new word only affects the next frame. The break control is the exception: it acts on the output at once, for as long as it is set. The top bit of the word has no effect.

Top module: `serial_tx_framer`

## Requirements
- R1: After reset and between frames, the line `txd` is 1 and `in_ready` is 1. `in_ready` is 0 from the cycle after a byte is accepted until the stop period has ended.
- R2: Word length comes from `lcw[1:0]`: 00 sends 5 data bits, 01 sends 6, 10 sends 7 and 11 sends 8.
- R3: The start bit is 0. Every start, data and parity bit lasts 16 baud ticks, counted only on cycles where `baud_tick` is 1. Data bits go out least significant bit first.
- R4: When `lcw[3]`=1 and `lcw[5]`=0, a parity bit follows the data. It is computed over the selected data bits only: `lcw[4]`=0 gives odd parity and `lcw[4]`=1 gives even parity. When `lcw[3]`=0, no parity bit is sent.
- R5: When `lcw[3]`=1 and `lcw[5]`=1, the parity bit is a constant: 1 if `lcw[4]`=0 and 0 if `lcw[4]`=1.
- R6: The stop period is high. Its length is 16 ticks when `lcw[2]`=0. When `lcw[2]`=1 it is 24 ticks for 5-bit words and 32 ticks for 6, 7 or 8-bit words.
- R7: While `lcw[6]`=1, `txd` is 0, whether the block is idle or busy. The frame keeps its normal timing underneath, so `in_ready` rises at the same tick as it would without break.
- R8: The format fields `lcw[5:0]` are captured when a byte is accepted. A change to them during a frame does not affect that frame.
- R9: `lcw[7]` has no effect on the frame.
- R10: A byte is accepted on a rising clock edge where both `in_valid` and `in_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| lcw | input | 8 | Line control word |
| in_valid | input | 1 | Producer offers `in_data` |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Framer is idle and will take a byte |
| txd | output | 1 | Serial output, high when idle |

## Verification
Four properties are checked on every cycle:
- `in_ready` drops right after an accept.
- The cycle in which `in_ready` falls shows a low start bit.
- The last busy cycle before `in_ready` rises is high, unless break is set.
- The captured format holds steady for the whole frame.

The bit counter is also checked against its limit. Other behaviour can only be shown by the bench, which compares every busy cycle of `txd` with a frame it computes itself:
- word length, parity and stop length over every combination of the low six control bits;
- sparse baud ticks;
- a control word changed mid-frame;
- a break pulse inside a frame;
- a set top bit of the control word.

// File: rtl/stx_pkg.sv
package stx_pkg;

    // Line control word, most significant field first
    typedef struct packed {
        logic       div_sel;    // accepted, no effect
        logic       brk_on;     // force line low
        logic       par_stick;  // constant parity bit
        logic       par_even;   // even parity / stick value select
        logic       par_on;     // parity bit present
        logic       stop_long;  // 1.5 or 2 stop bits
        logic [1:0] wlen;       // 5..8 data bits
    } fmt_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } phase_t;

    function automatic logic [3:0] data_bits(input logic [1:0] w);
        return 4'd5 + {2'b00, w};
    endfunction

endpackage

// File: rtl/stx_parity.sv
module stx_parity (
    input  logic          [7:0] data,
    input  stx_pkg::fmt_t       fmt,
    output logic                par_bit
);
    logic [7:0] mask;
    logic       xr;

    always_comb begin
        for (int i = 0; i < 8; i++) begin
            mask[i] = (4'(i) < stx_pkg::data_bits(fmt.wlen));
        end
        xr = ^(data & mask);
        if (fmt.par_stick) begin
            par_bit = ~fmt.par_even;
        end else if (fmt.par_even) begin
            par_bit = xr;
        end else begin
            par_bit = ~xr;
        end
    end
endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] last,
    output logic          expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = run && tick && (cnt_q == last);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || expire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= last));
endmodule

// File: rtl/serial_tx_framer.sv
module serial_tx_framer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [7:0] lcw,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       txd
);
    import stx_pkg::*;

    localparam int HALF = TICKS_PER_BIT / 2;
    localparam int CW   = $clog2(2 * TICKS_PER_BIT + 1);

    typedef struct packed {
        phase_t     ph;
        logic [7:0] sh;
        logic [2:0] idx;
        fmt_t       fmt;
        logic       par;
    } st_t;

    localparam st_t RST_ST = '{PH_IDLE, 8'h00, 3'd0, fmt_t'(8'h00), 1'b0};

    st_t           q, d;
    fmt_t          fmt_in;
    logic          par_new;
    logic          expire;
    logic [CW-1:0] last;
    logic          line;

    assign fmt_in = fmt_t'(lcw);

    stx_parity u_par (
        .data    (in_data),
        .fmt     (fmt_in),
        .par_bit (par_new)
    );

    always_comb begin
        if (q.ph != PH_STOP || !q.fmt.stop_long) begin
            last = CW'(TICKS_PER_BIT - 1);
        end else if (q.fmt.wlen == 2'b00) begin
            last = CW'(TICKS_PER_BIT + HALF - 1);
        end else begin
            last = CW'(2 * TICKS_PER_BIT - 1);
        end
    end

    stx_bit_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (q.ph != PH_IDLE),
        .tick   (baud_tick),
        .last   (last),
        .expire (expire)
    );

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (in_valid) begin
                    d.ph  = PH_START;
                    d.sh  = in_data;
                    d.idx = 3'd0;
                    d.fmt = fmt_in;
                    d.par = par_new;
                end
            end
            PH_START: if (expire) d.ph = PH_DATA;
            PH_DATA: begin
                if (expire) begin
                    d.sh = q.sh >> 1;
                    if ({1'b0, q.idx} == data_bits(q.fmt.wlen) - 4'd1) begin
                        d.idx = 3'd0;
                        d.ph  = q.fmt.par_on ? PH_PAR : PH_STOP;
                    end else begin
                        d.idx = q.idx + 3'd1;
                    end
                end
            end
            PH_PAR:  if (expire) d.ph = PH_STOP;
            PH_STOP: if (expire) d.ph = PH_IDLE;
            default: d = RST_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_ST;
        else        q <= d;
    end

    always_comb begin
        case (q.ph)
            PH_START: line = 1'b0;
            PH_DATA:  line = q.sh[0];
            PH_PAR:   line = q.par;
            default:  line = 1'b1;
        endcase
    end

    assign in_ready = (q.ph == PH_IDLE);
    assign txd      = line & ~lcw[6];

    // R10
    take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> !txd);

    // R6
    stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> ($past(txd) || $past(lcw[6])));

    // R8
    fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && $past(!in_ready)) |-> $stable(q.fmt));
endmodule

// File: tb/sim_serial_tx_framer.sv
module sim_serial_tx_framer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic [7:0] lcw = 8'h00;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;

    int checks = 0;
    int fails = 0;
    int tick_div = 1;
    int tcnt = 0;

    serial_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .lcw(lcw),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (tcnt >= tick_div - 1) tcnt <= 0;
        else                      tcnt <= tcnt + 1;
        baud_tick <= (tcnt == 0);
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bit(input int pos, input logic [7:0] dv, input logic [7:0] cw);
        int n, slot, ones;
        n = 5 + int'(cw[1:0]);
        if (pos < 16) return 1'b0;
        slot = pos / 16 - 1;
        if (slot < n) return dv[slot];
        if (cw[3] && slot == n) begin
            if (cw[5]) return ~cw[4];
            ones = 0;
            for (int i = 0; i < n; i++) ones += int'(dv[i]);
            return cw[4] ? bit'(ones % 2) : ~bit'(ones % 2);
        end
        return 1'b1;
    endfunction

    function automatic int frame_ticks(input logic [7:0] cw);
        int n, stop;
        n = 5 + int'(cw[1:0]);
        if (!cw[2])       stop = 16;
        else if (n == 5)  stop = 24;
        else              stop = 32;
        return 16 * (1 + n + int'(cw[3])) + stop;
    endfunction

    // Sends one byte and compares every busy cycle with the computed frame.
    task automatic send_frame(input string tag, input logic [7:0] dv, input logic [7:0] cw,
                              input bit chg, input logic [7:0] cw2, input int brk_at);
        int seen, total, bad, badact, badexp;
        bit e;
        @(negedge clk);
        lcw = cw;
        in_data = dv;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        total = frame_ticks(cw);
        seen = 0;
        bad = 0;
        badact = 0;
        badexp = 0;
        while (seen < total) begin
            e = lcw[6] ? 1'b0 : exp_bit(seen, dv, cw);
            if (bad == 0 && ({in_ready, txd} != {1'b0, e})) begin
                bad = 1;
                badact = {30'd0, in_ready, txd};
                badexp = {30'd0, 1'b0, e};
            end
            if (chg && seen >= 20) lcw = cw2;
            if (brk_at >= 0) lcw[6] = (seen >= brk_at && seen < brk_at + 20);
            if (baud_tick) seen++;
            @(negedge clk);
        end
        check({tag, " frame bits"}, badact, badexp);
        // R1: ready back and line high right after the last stop tick
        check({tag, " R1 ready after stop"}, {in_ready, txd}, {1'b1, ~lcw[6]});
        lcw = chg ? cw2 : cw;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset idle", {in_ready, txd}, 2'b11);

        // R7: break while idle forces the line low, ready stays high
        lcw = 8'h40;
        @(negedge clk);
        check("R7 idle break", {in_ready, txd}, 2'b10);
        lcw = 8'h00;
        @(negedge clk);
        check("R7 break release", {in_ready, txd}, 2'b11);

        // R2 R4 R5 R6: every format of the low six control bits
        for (int c = 0; c < 64; c++) begin
            send_frame("R2/R3/R4/R5/R6 sweep", 8'hA5 ^ 8'(c * 7), 8'(c), 1'b0, 8'h00, -1);
            send_frame("R2/R3/R4/R5/R6 sweep", 8'h3C ^ 8'(c * 13), 8'(c), 1'b0, 8'h00, -1);
        end

        // R9: top control bit has no effect
        send_frame("R9 top bit ignored", 8'hC6, 8'h9B, 1'b0, 8'h00, -1);
        send_frame("R9 top bit ignored", 8'h17, 8'hAC, 1'b0, 8'h00, -1);

        // R8: format change during a frame does not alter it
        send_frame("R8 mid change", 8'h5A, 8'h03, 1'b1, 8'h3C, -1);
        send_frame("R8 mid change", 8'h0F, 8'h28, 1'b1, 8'h07, -1);

        // R7: break pulse inside a frame, timing unchanged
        send_frame("R7 frame break", 8'h81, 8'h1F, 1'b0, 8'h00, 30);

        // R3: sparse baud ticks stretch bits by tick count only
        tick_div = 3;
        send_frame("R3 slow tick", 8'h81, 8'h0B, 1'b0, 8'h00, -1);
        tick_div = 5;
        send_frame("R3 slow tick", 8'h6D, 8'h34, 1'b0, 8'h00, -1);
        tick_div = 1;

        // R10: no accept without valid
        @(negedge clk);
        lcw = 8'h03;
        repeat (40) @(negedge clk);
        check("R10 no valid stays idle", {in_ready, txd}, 2'b11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule